// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits between a bus fetch sequencer and an instruction decoder. It holds up to six instruction bytes in first-in-first-out order. Whenever at least two byte slots are free and no fetch is outstanding, it asks the bus side for a 16-bit word at its running fetch address. Returned words are split into bytes, and the decoder takes them one at a time. When the queue is empty, a byte that arrives in a cycle is visible to the decoder in that same cycle.

A branch raises `flush` with a new byte address. The queue empties and fetching restarts at that address. An odd target is fetched first as a single byte so that every later fetch is word-aligned. Data from a fetch that was already accepted when the flush came is thrown away. A registered 2-bit status code lets outside logic mirror each queue operation, one clock after it happens.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty (`byteValid`=0), `qStatus`=00, and a word request is raised at address RESET_ADDR (default 0) with `reqByte`=0.
- R2: `reqValid` is high only when no fetch is outstanding, `flush` is low and at least 2 of the DEPTH (6) slots are free. With six bytes held it is low.
- R3: A word fetch delivers `rspData[7:0]` before `rspData[15:8]`. After an accepted word request, the next request address is 2 higher.
- R4: Bytes leave in arrival order, and the queue holds up to 6 bytes.
- R5: While the queue is empty, a byte arriving on `rspValid` appears on `byteOut` with `byteValid`=1 in the same cycle.
- R6: `flush` empties the queue by the next cycle and sets the next request address to `flushAddr`.
- R7: When the fetch address is odd, the request has `reqByte`=1 and its byte is taken from `rspData[15:8]`. The following request is at the next (even) address with `reqByte`=0.
- R8: A response to a fetch that was accepted before a flush is discarded. No new request is raised until that response has arrived.
- R9: `qStatus` reports the previous cycle's operation: 10 on flush (this wins over a take), 01 for a take with `first`=1, 11 for a take with `first`=0, and 00 otherwise.
- R10: A take in the same cycle as an arrival consumes the oldest byte and keeps the rest, with no loss or duplication.
- R11: A take while no byte is available has no effect and reports 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty queue and redirect fetching |
| flushAddr | input | ADDR_W | New fetch byte address |
| reqValid | output | 1 | Fetch request to bus sequencer |
| reqAddr | output | ADDR_W | Byte address of the request |
| reqByte | output | 1 | Request is a single odd byte |
| reqAck | input | 1 | Bus sequencer accepted the request |
| rspValid | input | 1 | Fetched data returned |
| rspData | input | 16 | Returned word (odd single byte in [15:8]) |
| byteValid | output | 1 | A byte is available to the decoder |
| byteOut | output | 8 | Oldest byte |
| take | input | 1 | Decoder consumes `byteOut` |
| first | input | 1 | The byte taken starts an opcode |
| qStatus | output | 2 | Registered queue status code |

## Verification
Two functions can fall in the same cycle. The first case is a data arrival together with a decoder take. The bench drives `rspValid` and `take` in the same cycle on an empty queue. It then expects the arriving low byte on `byteOut` at once, and the high byte as the only one left in the next cycle. The second case is a flush together with a take, or a flush together with a late response. These are judged from the status code (10) and from the queue staying empty, with no request raised until the old response has arrived.

// File: rtl/pq_pkg.sv
package pq_pkg;

  typedef struct packed {
    logic       clear;    // drop all contents
    logic       pop;      // remove the head byte
    logic [1:0] pushCnt;  // number of bytes written this cycle
    logic       hiOnly;   // single byte lives in the upper lane
  } qCtl_t;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qStat_e;

endpackage

// File: rtl/pq_store.sv
module pq_store
  import pq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  qCtl_t            ctl,
  input  logic [15:0]      inWord,
  output logic [CNT_W-1:0] count,
  output logic             avail,
  output logic [7:0]       headByte
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PTR_W-1:0] wrapInc(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  logic [7:0]       slot [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr, wrPtrB;
  logic [7:0]       byteA, byteB;

  assign byteA  = ctl.hiOnly ? inWord[15:8] : inWord[7:0];
  assign byteB  = inWord[15:8];
  assign wrPtrB = wrapInc(wrPtr);

  assign avail    = (count != '0) || (ctl.pushCnt != 2'd0);
  assign headByte = (count == '0) ? byteA : slot[rdPtr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!ctl.clear) begin
        if (ctl.pushCnt != 2'd0 && int'(wrPtr) == i)
          slot[i] <= byteA;
        else if (ctl.pushCnt == 2'd2 && int'(wrPtrB) == i)
          slot[i] <= byteB;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.pop) rdPtr <= wrapInc(rdPtr);
      case (ctl.pushCnt)
        2'd1:    wrPtr <= wrPtrB;
        2'd2:    wrPtr <= wrapInc(wrPtrB);
        default: wrPtr <= wrPtr;
      endcase
      count <= count + CNT_W'(ctl.pushCnt) - CNT_W'(ctl.pop);
    end
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= DEPTH);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pushCnt != 2'd0 && !ctl.clear) |-> int'(count) + int'(ctl.pushCnt) <= DEPTH);

  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> count == '0);

endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import pq_pkg::*;
#(
  parameter int          DEPTH      = 6,
  parameter int          ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter int          CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic              reqAck,
  input  logic              rspValid,
  input  logic              take,
  input  logic              first,
  input  logic [CNT_W-1:0]  count,
  input  logic              avail,
  output qCtl_t             ctl,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqByte,
  output logic [1:0]        qStatus
);

  localparam int LIMIT = DEPTH - 2;

  logic inFlight, discard, pendByte;

  assign reqByte  = reqAddr[0];
  assign reqValid = !inFlight && !flush && (int'(count) <= LIMIT);

  always_comb begin
    ctl.clear   = flush;
    ctl.hiOnly  = pendByte;
    ctl.pushCnt = 2'd0;
    if (rspValid && !discard && !flush)
      ctl.pushCnt = pendByte ? 2'd1 : 2'd2;
    ctl.pop = take && !flush && avail;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= RESET_ADDR;
      inFlight <= 1'b0;
      discard  <= 1'b0;
      pendByte <= 1'b0;
      qStatus  <= QS_IDLE;
    end else begin
      if (flush) begin
        reqAddr <= flushAddr;
      end else if (reqValid && reqAck) begin
        reqAddr  <= reqAddr + (reqByte ? ADDR_W'(1) : ADDR_W'(2));
        pendByte <= reqByte;
      end

      if (reqValid && reqAck) inFlight <= 1'b1;
      else if (rspValid)      inFlight <= 1'b0;

      if (rspValid)                discard <= 1'b0;
      else if (flush && inFlight)  discard <= 1'b1;

      if (flush)        qStatus <= QS_FLUSH;
      else if (ctl.pop) qStatus <= first ? QS_FIRST : QS_NEXT;
      else              qStatus <= QS_IDLE;
    end
  end

  p_flush_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> qStatus == QS_FLUSH);

  p_discard_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    discard |-> count == '0);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAck && !reqByte) |=> reqAddr == $past(reqAddr) + ADDR_W'(2));

  p_odd_align_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAck && reqByte) |=> !reqByte);

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pq_pkg::*;
#(
  parameter int                DEPTH      = 6,
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqByte,
  input  logic              reqAck,
  input  logic              rspValid,
  input  logic [15:0]       rspData,
  output logic              byteValid,
  output logic [7:0]        byteOut,
  input  logic              take,
  input  logic              first,
  output logic [1:0]        qStatus
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  qCtl_t            ctl;
  logic [CNT_W-1:0] count;

  pq_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .flushAddr(flushAddr),
    .reqAck(reqAck), .rspValid(rspValid), .take(take), .first(first),
    .count(count), .avail(byteValid), .ctl(ctl), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqByte(reqByte), .qStatus(qStatus)
  );

  pq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inWord(rspData),
    .count(count), .avail(byteValid), .headByte(byteOut)
  );

endmodule

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          flush = 1'b0;
  logic [AW-1:0] flushAddr = '0;
  logic          reqValid, reqByte, reqAck = 1'b0, rspValid = 1'b0;
  logic [AW-1:0] reqAddr;
  logic [15:0]   rspData = '0;
  logic          byteValid, take = 1'b0, first = 1'b0;
  logic [7:0]    byteOut;
  logic [1:0]    qStatus;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prefetch_queue u_prefetch_queue (
    .clk(clk), .rstN(rstN), .flush(flush), .flushAddr(flushAddr),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqByte(reqByte), .reqAck(reqAck),
    .rspValid(rspValid), .rspData(rspData), .byteValid(byteValid),
    .byteOut(byteOut), .take(take), .first(first), .qStatus(qStatus)
  );

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return a[7:0] * 8'd37 + 8'h11;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // take, first, expected status one clock later
  localparam logic [3:0] VEC [8] = '{
    {1'b1, 1'b1, 2'b01}, {1'b1, 1'b0, 2'b11}, {1'b0, 1'b0, 2'b00}, {1'b1, 1'b0, 2'b11},
    {1'b1, 1'b1, 2'b01}, {1'b0, 1'b1, 2'b00}, {1'b1, 1'b0, 2'b11}, {1'b1, 1'b1, 2'b01}
  };

  task automatic fetchWord(input string req, input logic [AW-1:0] expAddr);
    chk({req, " reqValid"}, 32'(reqValid), 32'd1);
    chk({req, " reqAddr"}, 32'(reqAddr), 32'(expAddr));
    chk({req, " reqByte"}, 32'(reqByte), 32'd0);
    reqAck = 1'b1;
    @(negedge clk);
    reqAck = 1'b0;
    rspValid = 1'b1;
    rspData = {mb(expAddr + 1), mb(expAddr)};
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 byteValid", 32'(byteValid), 32'd0);
    chk("R1 qStatus", 32'(qStatus), 32'd0);
    chk("R1 reqValid", 32'(reqValid), 32'd1);
    chk("R1 reqAddr", 32'(reqAddr), 32'd0);
    @(negedge clk);

    // R3 word fetches, addresses step by 2; R2 stops when full
    fetchWord("R3", 20'd0);
    fetchWord("R3", 20'd2);
    fetchWord("R3", 20'd4);
    chk("R2 full no request", 32'(reqValid), 32'd0);

    // R4 / R9 vector walk
    idx = 0;
    for (int v = 0; v < 8; v++) begin
      take = VEC[v][3];
      first = VEC[v][2];
      #1;
      if (VEC[v][3]) begin
        chk("R4 byte order", 32'(byteOut), 32'(mb(AW'(idx))));
        idx++;
      end
      @(negedge clk);
      chk("R9 status code", 32'(qStatus), 32'(VEC[v][1:0]));
    end
    take = 1'b0;
    first = 1'b0;
    #1;
    chk("R4 drained", 32'(byteValid), 32'd0);
    chk("R2 space request", 32'(reqAddr), 32'd6);

    // R11 take while empty
    @(negedge clk);
    take = 1'b1; first = 1'b1;
    @(negedge clk);
    take = 1'b0; first = 1'b0;
    chk("R11 status", 32'(qStatus), 32'd0);
    chk("R11 still empty", 32'(byteValid), 32'd0);

    // R5 bypass, R10 take with arrival
    chk("R3 next addr", 32'(reqAddr), 32'd6);
    reqAck = 1'b1;
    @(negedge clk);
    reqAck = 1'b0;
    rspValid = 1'b1;
    rspData = {mb(7), mb(6)};
    take = 1'b1; first = 1'b1;
    #1;
    chk("R5 bypass valid", 32'(byteValid), 32'd1);
    chk("R5 bypass byte", 32'(byteOut), 32'(mb(6)));
    @(negedge clk);
    rspValid = 1'b0; take = 1'b0; first = 1'b0;
    #1;
    chk("R10 status", 32'(qStatus), 32'd1);
    chk("R10 remaining byte", 32'(byteOut), 32'(mb(7)));
    chk("R10 valid", 32'(byteValid), 32'd1);

    // R6 / R9 flush with take, odd target
    @(negedge clk);
    flush = 1'b1; flushAddr = 20'h00101;
    take = 1'b1; first = 1'b0;
    #1;
    chk("R2 flush blocks request", 32'(reqValid), 32'd0);
    @(negedge clk);
    flush = 1'b0; take = 1'b0;
    #1;
    chk("R9 flush wins", 32'(qStatus), 32'd2);
    chk("R6 emptied", 32'(byteValid), 32'd0);
    chk("R6 new addr", 32'(reqAddr), 32'h101);
    chk("R7 single byte", 32'(reqByte), 32'd1);

    // R7 odd byte from upper lane
    reqAck = 1'b1;
    @(negedge clk);
    reqAck = 1'b0;
    rspValid = 1'b1;
    rspData = {mb(20'h101), 8'hEE};
    #1;
    chk("R7 upper lane", 32'(byteOut), 32'(mb(20'h101)));
    @(negedge clk);
    rspValid = 1'b0;
    #1;
    chk("R7 aligned addr", 32'(reqAddr), 32'h102);
    chk("R7 word again", 32'(reqByte), 32'd0);

    // R8 in-flight response discarded
    reqAck = 1'b1;
    @(negedge clk);
    reqAck = 1'b0;
    flush = 1'b1; flushAddr = 20'h00200;
    @(negedge clk);
    flush = 1'b0;
    rspValid = 1'b1;
    rspData = {mb(20'h103), mb(20'h102)};
    #1;
    chk("R8 dropped", 32'(byteValid), 32'd0);
    chk("R8 no request yet", 32'(reqValid), 32'd0);
    @(negedge clk);
    rspValid = 1'b0;
    #1;
    chk("R8 still empty", 32'(byteValid), 32'd0);
    chk("R8 request resumes", 32'(reqAddr), 32'h200);
    fetchWord("R6", 20'h200);
    #1;
    chk("R6 target byte", 32'(byteOut), 32'(mb(20'h200)));
    take = 1'b1;
    @(negedge clk);
    take = 1'b0;
    #1;
    chk("R4 target second", 32'(byteOut), 32'(mb(20'h201)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule